// File: doc/BRIEF.md
# Two-Stage Delay Line Alignment Controller

This block computes the select bits for a chain of switchable delay sections, with lengths halving from one section to the next, that bring incoming packets into line with the node's master timeslot. For every packet header, upstream logic reports a measured offset: the number of bytes of delay the packet still needs to reach the timeslot grid. The controller splits this delay into two parts. The coarse part is a slowly tracked static delay, which comes from link length, carrier wavelength and temperature drift. It is taken from a filtered average and changes only after a clear drift. The fine part is the per-packet remainder, which absorbs jitter.

Both settings are held in a pending register. They reach the select outputs only on a slot-boundary strobe, so a delay section never switches while a packet is passing through it. After reset, or after header lock is lost, the block keeps every section at zero delay. It stays there until it has seen enough valid offsets to trust its average.

Top module: `delay_align_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sel_coarse`, `sel_fine` and `fine_clamped` are all zero.
- R2: The outputs change only on the clock edge at which `slot_strobe` is high. At that edge they take the pending setting as it stood before that edge.
- R3: A sample is accepted when `ofs_valid` and `hdr_lock` are both high. The pending setting stays zero until 8 samples have been accepted since reset or since the last loss of lock.
- R4: The running average is kept as a 12-bit accumulator A, scaled by 16. The first accepted sample n loads A = 16·n. Each later sample updates it to A − floor(A/16) + n. The average is floor(A/16), taken after the update.
- R5: On the 8th accepted sample, the coarse code becomes floor(average/16), and that average is stored as a reference. After that, the coarse code and the reference are reloaded the same way only when the new average differs from the reference by more than 8 bytes.
- R6: Each accepted sample, from the 8th onward, sets the pending fine value to offset − 16·coarse. The coarse code used is the one in force after that sample's own update.
- R7: If that difference is below 0, the pending fine value is 0. If it is above 15, the pending fine value is 15. In both cases the pending clamp flag is set; otherwise the flag is cleared.
- R8: While `hdr_lock` is low, samples are ignored. The sample count, average, reference, coarse code and pending setting are cleared. The next strobe therefore drives all outputs to zero.
- R9: Bit i of `sel_fine` adds 2^i bytes of delay. Bit j of `sel_coarse` adds 2^(j+4) bytes. The total delay is 16·`sel_coarse` + `sel_fine`.
- R10: If a sample and a strobe come in the same cycle, the strobe applies the setting that was pending before the sample. The sample's setting is applied at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node master clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_lock | input | 1 | Header recovery is locked; low clears all tracking |
| ofs_valid | input | 1 | `ofs_bytes` carries a new header measurement |
| ofs_bytes | input | 8 | Delay still needed to reach the slot grid, in bytes |
| slot_strobe | input | 1 | Slot boundary; the pending setting is applied |
| sel_coarse | output | 4 | Select bits of the coarse sections (weights 16..128 bytes) |
| sel_fine | output | 4 | Select bits of the fine sections (weights 1..8 bytes) |
| fine_clamped | output | 1 | The applied fine value was clamped to 0 or 15 |

## Verification
The assertions rely on three things about the inputs: `hdr_lock` is a clean level, a strobe lasts one cycle, and offsets are byte counts within the slot, so any 8-bit value is legal. The stimulus drives all inputs at the falling clock edge. It mixes a slowly wandering base offset with jitter of ±6 bytes, drops lock occasionally, and places strobes at random, sometimes in the same cycle as a sample. Directed sequences then push the fine remainder past both ends of its range and ramp the offset to force coarse reloads.

// File: rtl/alc_pkg.sv
package alc_pkg;

    localparam int OFS_W    = 8;
    localparam int FINE_W   = 4;
    localparam int COARSE_W = OFS_W - FINE_W;
    localparam int EMA_SH   = 4;
    localparam int ACC_W    = OFS_W + EMA_SH;
    localparam int ARM_CNT  = 8;
    localparam int CNT_W    = $clog2(ARM_CNT + 1);
    localparam int FINE_MAX = (1 << FINE_W) - 1;
    localparam int HYST     = 1 << (FINE_W - 1);

    typedef logic [OFS_W-1:0]    ofs_t;
    typedef logic [COARSE_W-1:0] coarse_t;
    typedef logic [FINE_W-1:0]   fine_t;
    typedef logic [ACC_W-1:0]    acc_t;

    typedef struct packed {
        coarse_t coarse;
        fine_t   fine;
        logic    clamped;
    } dl_setting_t;

    // Exponential moving average step; accumulator holds avg scaled by 2^EMA_SH.
    function automatic acc_t ema_next(input acc_t acc, input ofs_t ofs, input logic seed);
        acc_t r;
        if (seed)
            r = {ofs, {EMA_SH{1'b0}}};
        else
            r = acc - (acc >> EMA_SH) + {{EMA_SH{1'b0}}, ofs};
        return r;
    endfunction

    function automatic ofs_t abs_diff(input ofs_t a, input ofs_t b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    // Remainder left for the fine sections, clamped to their range.
    function automatic dl_setting_t split_fine(input ofs_t ofs, input coarse_t code);
        dl_setting_t s;
        logic signed [OFS_W:0] diff;
        diff = $signed({1'b0, ofs}) - $signed({1'b0, code, {FINE_W{1'b0}}});
        s.coarse = code;
        if (diff[OFS_W]) begin
            s.fine    = '0;
            s.clamped = 1'b1;
        end else if (diff > $signed((OFS_W+1)'(FINE_MAX))) begin
            s.fine    = fine_t'(FINE_MAX);
            s.clamped = 1'b1;
        end else begin
            s.fine    = diff[FINE_W-1:0];
            s.clamped = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/alc_ema_track.sv
module alc_ema_track
    import alc_pkg::*;
#(
    parameter int N_ARM = ARM_CNT
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample_en,
    input  ofs_t ofs,
    output ofs_t avg_now,
    output logic arm_edge,
    output logic armed
);
    localparam int SW = $clog2(N_ARM + 1);

    acc_t          acc_q;
    acc_t          acc_nx;
    logic [SW-1:0] seen_q;

    assign acc_nx   = ema_next(acc_q, ofs, seen_q == '0);
    assign avg_now  = acc_nx[ACC_W-1:EMA_SH];
    assign armed    = (seen_q == SW'(N_ARM));
    assign arm_edge = sample_en && (seen_q == SW'(N_ARM - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q  <= '0;
            seen_q <= '0;
        end else if (sample_en) begin
            acc_q <= acc_nx;
            if (!armed)
                seen_q <= seen_q + SW'(1);
        end
    end

    // R3: the sample count saturates at the arming threshold
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
        seen_q <= SW'(N_ARM));

    // R8: loss of lock restarts the count
    a_r8_clear_restarts: assert property (@(posedge clk) disable iff (rst)
        clear |=> (seen_q == '0));

endmodule

// File: rtl/alc_coarse_hyst.sv
module alc_coarse_hyst
    import alc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  logic    sample_en,
    input  logic    arm_edge,
    input  logic    armed,
    input  ofs_t    avg_now,
    output coarse_t code_now,
    output coarse_t code_q
);
    ofs_t ref_q;
    logic moved;
    logic reload;

    assign moved    = abs_diff(avg_now, ref_q) > OFS_W'(HYST);
    assign reload   = sample_en && (arm_edge || (armed && moved));
    assign code_now = reload ? avg_now[OFS_W-1:FINE_W] : code_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            code_q <= '0;
            ref_q  <= '0;
        end else if (reload) begin
            code_q <= avg_now[OFS_W-1:FINE_W];
            ref_q  <= avg_now;
        end
    end

    // R5: the coarse code moves only when a sample is taken
    a_r5_code_needs_sample: assert property (@(posedge clk) disable iff (rst)
        (!sample_en && !clear) |=> $stable(code_q));

endmodule

// File: rtl/alc_fine_split.sv
module alc_fine_split
    import alc_pkg::*;
(
    input  ofs_t        ofs,
    input  coarse_t     code,
    output dl_setting_t setting
);
    assign setting = split_fine(ofs, code);

    // R7: a clamped remainder sits on one end of the fine range
    always_comb begin
        a_r7_clamp_ends: assert (!setting.clamped || setting.fine == '0
                                 || setting.fine == fine_t'(FINE_MAX));
    end

endmodule

// File: rtl/delay_align_ctrl.sv
module delay_align_ctrl
    import alc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                hdr_lock,
    input  logic                ofs_valid,
    input  logic [OFS_W-1:0]    ofs_bytes,
    input  logic                slot_strobe,
    output logic [COARSE_W-1:0] sel_coarse,
    output logic [FINE_W-1:0]   sel_fine,
    output logic                fine_clamped
);
    logic        sample_en;
    logic        clear;
    ofs_t        avg_now;
    logic        arm_edge;
    logic        armed;
    coarse_t     code_now;
    coarse_t     code_q;
    dl_setting_t split_w;
    dl_setting_t pend_q;
    dl_setting_t live_q;

    assign sample_en = ofs_valid && hdr_lock;
    assign clear     = !hdr_lock;

    alc_ema_track #(.N_ARM(ARM_CNT)) ema_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .sample_en (sample_en),
        .ofs       (ofs_bytes),
        .avg_now   (avg_now),
        .arm_edge  (arm_edge),
        .armed     (armed)
    );

    alc_coarse_hyst coarse_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .sample_en (sample_en),
        .arm_edge  (arm_edge),
        .armed     (armed),
        .avg_now   (avg_now),
        .code_now  (code_now),
        .code_q    (code_q)
    );

    alc_fine_split fine_i (
        .ofs     (ofs_bytes),
        .code    (code_now),
        .setting (split_w)
    );

    always_ff @(posedge clk) begin
        if (rst || clear)
            pend_q <= '0;
        else if (sample_en && (armed || arm_edge))
            pend_q <= split_w;
    end

    always_ff @(posedge clk) begin
        if (rst)
            live_q <= '0;
        else if (slot_strobe)
            live_q <= pend_q;
    end

    assign sel_coarse   = live_q.coarse;
    assign sel_fine     = live_q.fine;
    assign fine_clamped = live_q.clamped;

    // R2: select bits hold between slot boundaries
    a_r2_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
        !slot_strobe |=> ($stable(sel_coarse) && $stable(sel_fine) && $stable(fine_clamped)));

    // R3: nothing is pending before the block has armed
    a_r3_zero_until_armed: assert property (@(posedge clk) disable iff (rst)
        (!armed && !arm_edge) |=> (pend_q == '0));

    // R5: pending coarse code agrees with the tracked code
    a_r5_pending_tracks_code: assert property (@(posedge clk) disable iff (rst)
        armed |-> (pend_q.coarse == code_q));

    // R8: a strobe during a lasting loss of lock yields zero delay
    a_r8_unlock_zero: assert property (@(posedge clk) disable iff (rst)
        (slot_strobe && !hdr_lock && $past(!hdr_lock)) |=>
            (sel_coarse == '0 && sel_fine == '0 && !fine_clamped));

endmodule

// File: tb/delay_align_ctrl_tb_top.sv
module delay_align_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       hdr_lock;
    logic       ofs_valid;
    logic [7:0] ofs_bytes;
    logic       slot_strobe;
    logic [3:0] sel_coarse;
    logic [3:0] sel_fine;
    logic       fine_clamped;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    // reference model state
    int m_acc = 0, m_cnt = 0, m_ref = 0, m_code = 0;
    int p_c = 0, p_f = 0, p_k = 0;
    int o_c = 0, o_f = 0, o_k = 0;

    always #10 clk = ~clk;

    delay_align_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .hdr_lock     (hdr_lock),
        .ofs_valid    (ofs_valid),
        .ofs_bytes    (ofs_bytes),
        .slot_strobe  (slot_strobe),
        .sel_coarse   (sel_coarse),
        .sel_fine     (sel_fine),
        .fine_clamped (fine_clamped)
    );

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic model_reset();
        m_acc = 0; m_cnt = 0; m_ref = 0; m_code = 0;
        p_c = 0; p_f = 0; p_k = 0;
    endtask

    task automatic model_edge(input bit lk, input bit v, input bit s, input int ofs);
        int avg, d;
        if (s) begin o_c = p_c; o_f = p_f; o_k = p_k; end
        if (!lk) begin
            model_reset();
        end else if (v) begin
            if (m_cnt == 0) m_acc = ofs * 16;
            else m_acc = m_acc - (m_acc / 16) + ofs;
            avg = m_acc / 16;
            if (m_cnt < 8) begin
                m_cnt++;
                if (m_cnt == 8) begin m_code = avg / 16; m_ref = avg; end
            end else if (iabs(avg - m_ref) > 8) begin
                m_code = avg / 16; m_ref = avg;
            end
            if (m_cnt == 8) begin
                d = ofs - 16 * m_code;
                p_c = m_code;
                if (d < 0)       begin p_f = 0;  p_k = 1; end
                else if (d > 15) begin p_f = 15; p_k = 1; end
                else             begin p_f = d;  p_k = 0; end
            end
        end
    endtask

    task automatic compare(input string tag);
        nvec++;
        if (sel_coarse !== 4'(o_c) || sel_fine !== 4'(o_f) || fine_clamped !== 1'(o_k)) begin
            nfail++;
            $display("FAIL %s: got coarse=%0d fine=%0d clamp=%0d, expected coarse=%0d fine=%0d clamp=%0d",
                     tag, sel_coarse, sel_fine, fine_clamped, o_c, o_f, o_k);
        end
    endtask

    // called at a falling edge; drives, crosses one rising edge, checks at next falling edge
    task automatic step(input bit lk, input bit v, input bit s, input int ofs, input string tag);
        hdr_lock = lk; ofs_valid = v; slot_strobe = s; ofs_bytes = 8'(ofs);
        @(posedge clk);
        model_edge(lk, v, s, ofs);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog R2: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'd2718));
        rst = 1'b1; hdr_lock = 1'b0; ofs_valid = 1'b0; ofs_bytes = '0; slot_strobe = 1'b0;
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        hdr_lock = 1'b1; ofs_valid = 1'b1; slot_strobe = 1'b1; ofs_bytes = 8'd77;
        @(negedge clk);
        compare("R1 reset with strobe");
        rst = 1'b0;
        model_reset(); o_c = 0; o_f = 0; o_k = 0;
        step(1, 0, 1, 0, "R1 first cycle after reset");

        // R3: seven samples leave outputs at zero
        for (int i = 0; i < 7; i++) step(1, 1, 1, 100 + (i % 3), "R3 before arming");
        // R5 R6 R9: eighth sample arms, strobe applies it
        step(1, 1, 0, 101, "R5 arming sample");
        step(1, 0, 1, 0, "R9 R6 applied after arming");
        // R2: samples without strobe leave outputs alone
        step(1, 1, 0, 99, "R2 hold");
        step(1, 1, 0, 103, "R2 hold");
        step(1, 0, 1, 0, "R6 applied");
        // R7: below and above the fine range
        step(1, 1, 0, 80, "R7 low sample");
        step(1, 0, 1, 0, "R7 clamp low");
        step(1, 1, 0, 130, "R7 high sample");
        step(1, 0, 1, 0, "R7 clamp high");
        step(1, 1, 0, 100, "R7 back in range");
        step(1, 0, 1, 0, "R7 clamp clears");
        // R10: sample and strobe in one cycle
        step(1, 1, 1, 107, "R10 same cycle");
        step(1, 0, 0, 0, "R10 old setting held");
        step(1, 0, 1, 0, "R10 new setting at next strobe");
        // R5: ramp forces coarse reloads
        for (int o = 100; o < 200; o += 2) step(1, 1, (o % 6) == 0, o, "R5 R4 ramp");
        step(1, 0, 1, 0, "R5 after ramp");
        // R8: loss of lock
        step(0, 1, 0, 50, "R8 unlock sample ignored");
        step(0, 1, 1, 50, "R8 unlock strobe zero");
        step(0, 0, 0, 0, "R8 zero held");
        for (int i = 0; i < 7; i++) step(1, 1, 1, 60, "R8 R3 relock rearm");
        step(1, 1, 1, 60, "R8 eighth sample");
        step(1, 0, 1, 0, "R8 armed again");

        // random traffic
        base = 120;
        for (int i = 0; i < 4000; i++) begin
            int j, o;
            bit lk, v, s;
            if ($urandom_range(0, 49) == 0) base = $urandom_range(20, 235);
            else if ($urandom_range(0, 3) == 0) base += $urandom_range(0, 2) - 1;
            if (base < 6) base = 6;
            if (base > 249) base = 249;
            j = $urandom_range(0, 12) - 6;
            o = base + j;
            lk = ($urandom_range(0, 299) != 0);
            v  = ($urandom_range(0, 2) != 0);
            s  = ($urandom_range(0, 3) == 0);
            step(lk, v, s, o, "R4 R5 R6 R7 R2 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule